// File: doc/BRIEF.md
# Functional Self-Test Program Sequencer

This block tests a small accumulator processor purely through its instruction port, its data input and its output register, with no structural access into the processor. It plays short instruction programs into the processor and drives the operand values it loads. It then compares the value that shows up on the processor output with a value that its own model of the instruction set predicts.

Every test step takes five clock cycles. The step loads R from the data input, loads A from the data input, and executes the operation under test. It then copies A to the output and, in the fifth cycle, compares that output. The scanning phase comes first. It runs the add instruction over a set of operand pairs that is generated inside the block. The conformity phase follows. It fixes R, A and the input value and executes each of the ten instructions in turn, which shows whether the decoder selects the right operation.

A single start pulse runs both phases. The run stops at the first mismatch and holds the phase, the step index and the value that was observed. Otherwise it finishes with a pass verdict.

Top module: `selftest_seq`

## Requirements
- R1: While reset is held and after it is released, busy, done, pass and fail are low, instr is 0 (no operation) and data_out is 0.
- R2: A start pulse while not busy begins a run in the next cycle. Each step takes five cycles, with instr = 5 and data_out = R operand, then instr = 1 and data_out = A operand, then the operation under test, then instr = 4, then instr = 0 while the output is compared. data_out is 0 in the last two cycles.
- R3: The scanning phase has 2·DATA_W+2 steps, and each step executes instr = 7 with data_out = 0 during the operation cycle. For step i < DATA_W, R = A = 1<<i. For DATA_W ≤ i < 2·DATA_W, R = 1<<(i−DATA_W) and A = all ones. The last two steps use all zeros for both operands and then all ones for both.
- R4: The conformity phase follows with 10 steps, where step k executes instruction k+1. It uses R = CONF_R, A = CONF_A, and data_out = CONF_IN during the operation cycle.
- R5: The expected output is the value of A after the operation. Codes 1 and 6 load the input value into A. Code 2 copies A to R. Codes 3, 4 and 5 leave A unchanged (5 loads R). Code 7 adds R to A modulo 2^DATA_W, code 8 ORs R into A, code 9 ANDs R into A, and code 10 inverts A.
- R6: On the first compare mismatch, the next cycle shows busy low, done and fail high and pass low. fail_phase is 0 for scan or 1 for conformity, fail_step holds the step index and fail_value holds the observed output. instr returns to 0.
- R7: When all steps match, the cycle after the last compare shows done and pass high, busy and fail low. The verdict holds until the next start.
- R8: A start pulse while busy has no effect on the running program.
- R9: A new start clears done, pass, fail and the latched failure fields, and repeats the full program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begins a test run when idle |
| proc_out | input | DATA_W | Processor output register |
| instr | output | OP_W (4) | Instruction code to the processor, 0 = no operation |
| data_out | output | DATA_W | Value for the processor data input |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished (pass or fail) |
| pass | output | 1 | Run finished with no mismatch |
| fail | output | 1 | Run stopped on a mismatch |
| fail_phase | output | 1 | Phase of the first mismatch (0 scan, 1 conformity) |
| fail_step | output | STEP_W | Step index of the first mismatch |
| fail_value | output | DATA_W | Output value observed at the first mismatch |

## Verification
The bench builds the block with its defaults: DATA_W = 8, which gives 18 scanning steps, and the conformity data 5A, 3C and C3. At this width a complete run takes only 140 cycles, so the whole program is compared instruction by instruction and operand by operand. The bench does this on a clean processor model, on one whose adder drops sum bit 4, and on one whose decoder executes OR in place of AND. These runs reach the passing end, a stop in the scanning phase and a stop in the conformity phase.

// File: rtl/stseq_pkg.sv
// Shared types of the self-test sequencer: instruction codes, step frames, phases.
package stseq_pkg;
    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP     = 4'd0,
        OP_LDA_IMM = 4'd1,
        OP_MOV_RA  = 4'd2,
        OP_OUT_R   = 4'd3,
        OP_OUT_A   = 4'd4,
        OP_LDR_IN  = 4'd5,
        OP_LDA_IN  = 4'd6,
        OP_ADD     = 4'd7,
        OP_OR      = 4'd8,
        OP_AND     = 4'd9,
        OP_CPL     = 4'd10
    } opcode_e;

    typedef enum logic [2:0] {
        FR_LOADR = 3'd0,
        FR_LOADA = 3'd1,
        FR_EXEC  = 3'd2,
        FR_SHOW  = 3'd3,
        FR_CHECK = 3'd4
    } frame_e;

    typedef enum logic {
        PH_SCAN = 1'b0,
        PH_CONF = 1'b1
    } phase_e;
endpackage

// File: rtl/seq_frame_ctrl.sv
// Run controller: walks frames within a step, steps within a phase, and the
// two phases; stops on a mismatch reported in the compare frame.
// Assumes cmp_bad is only meaningful while busy in FR_CHECK.
module seq_frame_ctrl
    import stseq_pkg::*;
#(
    parameter int SCAN_N = 18,
    parameter int CONF_N = 10,
    parameter int STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              cmp_bad,
    output logic              busy,
    output frame_e            frame,
    output phase_e            phase,
    output logic [STEP_W-1:0] step,
    output logic              done,
    output logic              pass,
    output logic              fail
);
    logic last_step;

    // last step of the current phase
    always_comb begin
        last_step = (phase == PH_SCAN) ? (step == STEP_W'(SCAN_N - 1))
                                       : (step == STEP_W'(CONF_N - 1));
    end

    // frame, step, phase and verdict sequencing
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            frame <= FR_LOADR;
            phase <= PH_SCAN;
            step  <= '0;
            done  <= 1'b0;
            pass  <= 1'b0;
            fail  <= 1'b0;
        end else if (!busy) begin
            if (start) begin
                busy  <= 1'b1;
                frame <= FR_LOADR;
                phase <= PH_SCAN;
                step  <= '0;
                done  <= 1'b0;
                pass  <= 1'b0;
                fail  <= 1'b0;
            end
        end else if (frame != FR_CHECK) begin
            frame <= frame_e'(frame + 3'd1);
        end else begin
            frame <= FR_LOADR;
            if (cmp_bad) begin
                busy <= 1'b0;
                done <= 1'b1;
                fail <= 1'b1;
            end else if (last_step) begin
                step <= '0;
                if (phase == PH_SCAN) begin
                    phase <= PH_CONF;
                end else begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    pass <= 1'b1;
                end
            end else begin
                step <= step + 1'b1;
            end
        end
    end

    // R2: frames advance one per cycle inside a step
    p_frame_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && frame != FR_CHECK) |=> (busy && frame == frame_e'($past(frame) + 3'd1)));
    // R3: scan step index stays inside the operand set
    p_scan_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase == PH_SCAN) |-> (int'(step) < SCAN_N));
    // R4: conformity step index stays inside the ten instructions
    p_conf_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && phase == PH_CONF) |-> (int'(step) < CONF_N));
    // R8: a start while busy never ends a run outside a compare frame
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && frame != FR_CHECK) |=> busy);
endmodule

// File: rtl/seq_operand_gen.sv
// Operand source: per phase and step, yields the operation code, R and A
// operands and the input value presented during the operation frame.
// Assumes step is within range of the phase.
module seq_operand_gen
    import stseq_pkg::*;
#(
    parameter int              DATA_W  = 8,
    parameter int              STEP_W  = 5,
    parameter logic [DATA_W-1:0] CONF_R  = 8'h5A,
    parameter logic [DATA_W-1:0] CONF_A  = 8'h3C,
    parameter logic [DATA_W-1:0] CONF_IN = 8'hC3
) (
    input  phase_e            phase,
    input  logic [STEP_W-1:0] step,
    output opcode_e           op,
    output logic [DATA_W-1:0] r_op,
    output logic [DATA_W-1:0] a_op,
    output logic [DATA_W-1:0] in_val
);
    localparam logic [DATA_W-1:0] ONE  = DATA_W'(1);
    localparam logic [DATA_W-1:0] ONES = '1;

    // operand selection: walking ones, walking ones against all ones, corners
    always_comb begin
        int idx;
        idx = int'(step);
        if (phase == PH_SCAN) begin
            op     = OP_ADD;
            in_val = '0;
            if (idx < DATA_W) begin
                r_op = ONE << idx;
                a_op = ONE << idx;
            end else if (idx < 2 * DATA_W) begin
                r_op = ONE << (idx - DATA_W);
                a_op = ONES;
            end else if (idx == 2 * DATA_W) begin
                r_op = '0;
                a_op = '0;
            end else begin
                r_op = ONES;
                a_op = ONES;
            end
        end else begin
            op     = opcode_e'(OP_W'(step) + OP_W'(1));
            in_val = CONF_IN;
            r_op   = CONF_R;
            a_op   = CONF_A;
        end
    end
endmodule

// File: rtl/seq_ref_model.sv
// Instruction-set reference: value of A after one operation, which the
// following output instruction makes visible. Purely combinational.
module seq_ref_model
    import stseq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] a_val,
    input  logic [DATA_W-1:0] r_val,
    input  logic [DATA_W-1:0] in_val,
    output logic [DATA_W-1:0] a_next
);
    // accumulator result per instruction
    always_comb begin
        case (op)
            OP_LDA_IMM, OP_LDA_IN: a_next = in_val;
            OP_ADD:                a_next = a_val + r_val;
            OP_OR:                 a_next = a_val | r_val;
            OP_AND:                a_next = a_val & r_val;
            OP_CPL:                a_next = ~a_val;
            default:               a_next = a_val;
        endcase
    end
endmodule

// File: rtl/selftest_seq.sv
// Self-test sequencer top: drives instruction programs and operands to an
// accumulator processor, compares its output against the reference model,
// and latches the first failure. Assumes the processor updates its output
// register on the clock edge that ends the instruction's cycle.
module selftest_seq
    import stseq_pkg::*;
#(
    parameter int                DATA_W  = 8,
    parameter logic [DATA_W-1:0] CONF_R  = 8'h5A,
    parameter logic [DATA_W-1:0] CONF_A  = 8'h3C,
    parameter logic [DATA_W-1:0] CONF_IN = 8'hC3,
    localparam int               SCAN_N  = 2 * DATA_W + 2,
    localparam int               CONF_N  = 10,
    localparam int               STEPS_MAX = (SCAN_N > CONF_N) ? SCAN_N : CONF_N,
    localparam int               STEP_W  = $clog2(STEPS_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] proc_out,
    output logic [OP_W-1:0]   instr,
    output logic [DATA_W-1:0] data_out,
    output logic              busy,
    output logic              done,
    output logic              pass,
    output logic              fail,
    output logic              fail_phase,
    output logic [STEP_W-1:0] fail_step,
    output logic [DATA_W-1:0] fail_value
);
    frame_e            frame;
    phase_e            phase;
    logic [STEP_W-1:0] step;
    opcode_e           op;
    logic [DATA_W-1:0] r_op, a_op, in_val, expect_val;
    logic              cmp_bad;

    seq_frame_ctrl #(.SCAN_N(SCAN_N), .CONF_N(CONF_N), .STEP_W(STEP_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cmp_bad(cmp_bad),
        .busy(busy), .frame(frame), .phase(phase), .step(step),
        .done(done), .pass(pass), .fail(fail)
    );

    seq_operand_gen #(.DATA_W(DATA_W), .STEP_W(STEP_W), .CONF_R(CONF_R),
                      .CONF_A(CONF_A), .CONF_IN(CONF_IN)) u_ops (
        .phase(phase), .step(step), .op(op),
        .r_op(r_op), .a_op(a_op), .in_val(in_val)
    );

    seq_ref_model #(.DATA_W(DATA_W)) u_ref (
        .op(op), .a_val(a_op), .r_val(r_op), .in_val(in_val), .a_next(expect_val)
    );

    // program and operand drive for the current frame
    always_comb begin
        instr    = OP_NOP;
        data_out = '0;
        if (busy) begin
            case (frame)
                FR_LOADR: begin instr = OP_LDR_IN; data_out = r_op;   end
                FR_LOADA: begin instr = OP_LDA_IMM; data_out = a_op;  end
                FR_EXEC:  begin instr = op;        data_out = in_val; end
                FR_SHOW:  instr = OP_OUT_A;
                default:  instr = OP_NOP;
            endcase
        end
    end

    // compare the observed output in the compare frame
    assign cmp_bad = busy && (frame == FR_CHECK) && (proc_out != expect_val);

    // failure record: cleared by an accepted start, loaded on the mismatch
    always_ff @(posedge clk) begin
        if (!rst_n || (!busy && start)) begin
            fail_phase <= 1'b0;
            fail_step  <= '0;
            fail_value <= '0;
        end else if (cmp_bad) begin
            fail_phase <= phase;
            fail_step  <= step;
            fail_value <= proc_out;
        end
    end

    // R7: a finished run carries exactly one verdict
    p_one_verdict_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pass ^ fail));
    // R2: an accepted start opens a run with the verdict cleared
    p_start_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !done));
    // R6: a failure stops the run and withholds pass
    p_fail_halts_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail) |-> (!busy && !pass && done));
    // R6: the record holds still while no run is active
    p_record_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start && $past(!busy)) |-> $stable(fail_step));
endmodule

// File: tb/selftest_seq_tb.sv
module selftest_seq_tb;
    localparam int W      = 8;
    localparam int SCAN_N = 2 * W + 2;
    localparam int CONF_N = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [W-1:0] proc_out;
    logic [3:0]   instr;
    logic [W-1:0] data_out;
    logic         busy, done, pass, fail, fail_phase;
    logic [4:0]   fail_step;
    logic [W-1:0] fail_value;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    int fault_sel = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    selftest_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .proc_out(proc_out),
        .instr(instr), .data_out(data_out), .busy(busy), .done(done),
        .pass(pass), .fail(fail), .fail_phase(fail_phase),
        .fail_step(fail_step), .fail_value(fail_value)
    );

    // processor model with optional injected defects
    function automatic logic [W-1:0] alu(int op, logic [W-1:0] a, logic [W-1:0] r,
                                         logic [W-1:0] inv, int fsel);
        case (op)
            1, 6: return inv;
            7:    return (fsel == 1) ? ((a + r) & ~8'h10) : (a + r);
            8:    return a | r;
            9:    return (fsel == 2) ? (a | r) : (a & r);
            10:   return ~a;
            default: return a;
        endcase
    endfunction

    logic [W-1:0] pa, pr;
    always @(posedge clk) begin
        if (!rst_n) begin
            pa <= '0; pr <= '0; proc_out <= '0;
        end else begin
            case (int'(instr))
                2: pr <= pa;
                3: proc_out <= pr;
                4: proc_out <= pa;
                5: pr <= data_out;
                default: ;
            endcase
            pa <= alu(int'(instr), pa, pr, data_out, fault_sel);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !finished) begin
            finished = 1;
            n_bad++;
            $display("FAIL watchdog: actual cycles %0d expected < 20000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // operand set from R3, held in queues
    logic [W-1:0] scan_r[$], scan_a[$];

    function automatic logic [W-1:0] golden(int op, logic [W-1:0] a, logic [W-1:0] r,
                                            logic [W-1:0] inv);
        return alu(op, a, r, inv, 0);
    endfunction

    // one complete run; mid_start pulses start during the run (R8)
    task automatic run(int fsel, bit mid_start);
        int exp_fail_step = -1;
        int exp_fail_ph = 0;
        logic [W-1:0] exp_fail_val = '0;
        fault_sel = fsel;
        for (int s = 0; s < SCAN_N + CONF_N; s++) begin
            logic [W-1:0] r, a, inv;
            int op;
            if (s < SCAN_N) begin r = scan_r[s]; a = scan_a[s]; inv = 0; op = 7; end
            else begin r = 8'h5A; a = 8'h3C; inv = 8'hC3; op = s - SCAN_N + 1; end
            if (alu(op, a, r, inv, fsel) != golden(op, a, r, inv)) begin
                exp_fail_step = (s < SCAN_N) ? s : s - SCAN_N;
                exp_fail_ph = (s < SCAN_N) ? 0 : 1;
                exp_fail_val = alu(op, a, r, inv, fsel);
                break;
            end
        end
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        begin : steps
            for (int s = 0; s < SCAN_N + CONF_N; s++) begin
                logic [W-1:0] r, a, inv;
                int op, ph, idx;
                ph = (s < SCAN_N) ? 0 : 1;
                idx = ph ? s - SCAN_N : s;
                if (!ph) begin r = scan_r[s]; a = scan_a[s]; inv = 0; op = 7; end
                else begin r = 8'h5A; a = 8'h3C; inv = 8'hC3; op = idx + 1; end
                for (int f = 0; f < 5; f++) begin
                    if (!(s == 0 && f == 0)) @(negedge clk);
                    start = 1'b0;
                    chk(busy === 1'b1, "R2 busy", busy, 1);
                    case (f)
                        0: begin chk(instr == 5, "R2 instr ldr", instr, 5);
                                 chk(data_out == r, ph ? "R4 R operand" : "R3 R operand", data_out, r); end
                        1: begin chk(instr == 1, "R2 instr lda", instr, 1);
                                 chk(data_out == a, ph ? "R4 A operand" : "R3 A operand", data_out, a); end
                        2: begin chk(instr == op, ph ? "R4 op under test" : "R3 add op", instr, op);
                                 chk(data_out == inv, ph ? "R4 input value" : "R3 input zero", data_out, inv); end
                        3: begin chk(instr == 4, "R2 instr out", instr, 4);
                                 chk(data_out == 0, "R2 data zero", data_out, 0); end
                        default: begin chk(instr == 0, "R2 instr nop", instr, 0);
                                 chk(data_out == 0, "R2 data zero", data_out, 0); end
                    endcase
                    if (mid_start && s == 2 && f == 1) start = 1'b1;
                end
                if (ph == exp_fail_ph && idx == exp_fail_step) disable steps;
            end
        end
        @(negedge clk);
        chk(busy == 0 && done == 1, "R6/R7 run ended", {busy, done}, 2'b01);
        if (exp_fail_step < 0) begin
            chk(pass == 1 && fail == 0, "R7 pass verdict", {pass, fail}, 2'b10);
        end else begin
            chk(pass == 0 && fail == 1, "R6 fail verdict", {pass, fail}, 2'b01);
            chk(fail_phase == exp_fail_ph, "R6 fail phase", fail_phase, exp_fail_ph);
            chk(fail_step == exp_fail_step, "R6 fail step", fail_step, exp_fail_step);
            chk(fail_value == exp_fail_val, "R6 fail value R5", fail_value, exp_fail_val);
        end
        chk(instr == 0, "R6 idle nop", instr, 0);
        repeat (3) @(negedge clk);
        chk(done == 1 && busy == 0, "R7 verdict held", {busy, done}, 2'b01);
    endtask

    initial begin
        for (int i = 0; i < W; i++) begin scan_r.push_back(W'(1) << i); scan_a.push_back(W'(1) << i); end
        for (int i = 0; i < W; i++) begin scan_r.push_back(W'(1) << i); scan_a.push_back('1); end
        scan_r.push_back('0); scan_a.push_back('0);
        scan_r.push_back('1); scan_a.push_back('1);

        repeat (3) @(negedge clk);
        chk({busy, done, pass, fail} == 0, "R1 flags in reset", {busy, done, pass, fail}, 0);
        chk(instr == 0 && data_out == 0, "R1 drive in reset", {instr, data_out}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk({busy, done, pass, fail} == 0, "R1 flags after reset", {busy, done, pass, fail}, 0);
        chk(instr == 0, "R1 instr after reset", instr, 0);

        run(0, 1'b1);   // clean processor, start pulsed mid-run (R8)
        run(1, 1'b0);   // adder defect: scan stop
        run(2, 1'b0);   // decoder defect: conformity stop
        run(0, 1'b0);   // R9: restart clears the failure
        chk(fail_step == 0 && fail_value == 0, "R9 record cleared", {fail_step, fail_value}, 0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule